// File: doc/BRIEF.md
# Integer Status Flag Update Unit

This block keeps the integer status flags of a 64-bit execution pipeline up to date. When an integer operation retires, the pipeline presents the operands it actually used, the result it produced and a handful of control bits on a single valid strobe. The block works out the carry flags, the overflow flags, a sticky summary-overflow bit and a 4-bit signed classification of the result. It registers all of them on that clock edge. The arithmetic itself, instruction decoding and every other condition field belong to the rest of the pipeline.

Carry is not taken from an adder carry-out. It is inferred by comparing each operand, as an unsigned number, against the result. This is done over the full width and again over the low half. Overflow is inferred from the signs of the first two operands and of the result, at both widths. A separate divide-overflow input forces both overflow flags. An instruction that writes a carry flag itself can supply that value through a per-flag suppression mask, and the block takes it in place of the inferred value.

Top module: `int_flag_unit`

## Requirements
- R1: While `rst_n` is low, every flag output and `cr0_q` read zero.
- R2: The operand list is built in this order: register operand 0, bitwise inverted when `invert_src0` is 1; then register operand 1; then `imm_val`. An entry takes part only when its valid bit is 1. `src_vld[i]` covers register operand i, and `imm_vld` covers the immediate. Register operand 0 sits in `src[63:0]` and register operand 1 in `src[127:64]`.
- R3: On an update with `carry_en`=1 and `carry_done[0]`=0, `ca_q` becomes 1 exactly when some operand in the list, read as an unsigned 64-bit value, is greater than `result`.
- R4: On an update with `carry_en`=1 and `carry_done[1]`=0, `ca32_q` follows the rule of R3 applied to bits 31:0 of the operands and of `result`.
- R5: On an update with `carry_en`=1, `carry_done[0]`=1 loads `ca_q` from `ca_pre`, and `carry_done[1]`=1 loads `ca32_q` from `ca32_pre`. Each mask bit acts on its own flag only.
- R6: `ca_q` and `ca32_q` hold their values on any cycle without both `op_vld` and `carry_en`.
- R7: On an overflow update without divide overflow, `ov_q` is 1 when the first two operands of the list have equal bit 63 and `result` bit 63 differs from it. `ov32_q` applies the same test at bit 31.
- R8: An overflow update with `div_ovf`=1 sets both `ov_q` and `ov32_q` to 1, whatever the operands.
- R9: An overflow update happens only when `op_vld`, `ovf_en` and either (at least two operands in the list, or `div_ovf`) are all 1. Otherwise `ov_q`, `ov32_q` and `so_q` hold.
- R10: `so_q` never falls outside reset. On each overflow update it becomes its old value OR the new `ov_q`.
- R11: An update with `rec_en`=1 writes `cr0_q` as bit 3 negative, bit 2 positive, bit 1 zero and bit 0 the summary bit after this same update. Sign and zero are judged on `result` as a signed value. With `rec_en`=0, `cr0_q` holds.
- R12: With `op_vld`=0, no output changes, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_vld | input | 1 | Update strobe for one completed operation |
| src | input | 128 | Register operands, packed 2 x 64, operand 0 in the low word |
| src_vld | input | 2 | Presence bit per register operand |
| invert_src0 | input | 1 | Invert register operand 0 before evaluation |
| imm_vld | input | 1 | Immediate operand present |
| imm_val | input | 64 | Immediate operand value |
| result | input | 64 | Result of the operation |
| carry_en | input | 1 | Carry flags are to be updated |
| carry_done | input | 2 | Bit 0: take ca_pre; bit 1: take ca32_pre |
| ca_pre | input | 1 | Full-width carry value written by the operation itself |
| ca32_pre | input | 1 | Low-half carry value written by the operation itself |
| ovf_en | input | 1 | Overflow flags are to be updated |
| div_ovf | input | 1 | Divide overflow indication |
| rec_en | input | 1 | Record the result class into cr0_q |
| ca_q | output | 1 | Full-width carry flag |
| ca32_q | output | 1 | Low-half carry flag |
| ov_q | output | 1 | Full-width overflow flag |
| ov32_q | output | 1 | Low-half overflow flag |
| so_q | output | 1 | Sticky summary overflow |
| cr0_q | output | 4 | {negative, positive, zero, summary} |

## Verification
The bench targets results where the two widths disagree: a low-half carry with no full-width carry, and a low-half overflow with no full-width overflow. A design that shared one comparator or one sign bit between the widths would set both flags or neither. It places an invalid register operand whose sign would fake an overflow next to a valid immediate, so a design that ignored the valid bits or mis-ordered the list reports OV. Divide overflow with a single operand, overflow updates with only one operand, and masked carry loads with opposite mask bits expose gating and suppression errors as flags that move when they should hold. A negative result recorded with summary set, then clear, catches a CR0 field built from the stale summary bit.

// File: rtl/flagu_pkg.sv
package flagu_pkg;

    localparam int CR_FIELD_W = 4;

    typedef struct packed {
        logic                  ca;
        logic                  ca32;
        logic                  ov;
        logic                  ov32;
        logic                  so;
        logic [CR_FIELD_W-1:0] cr0;
    } flag_state_t;

    localparam flag_state_t FLAG_RESET = '{ca: 1'b0, ca32: 1'b0, ov: 1'b0,
                                           ov32: 1'b0, so: 1'b0, cr0: '0};

endpackage

// File: rtl/flagu_carry.sv
module flagu_carry #(
    parameter int XLEN  = 64,
    parameter int HALF  = 32,
    parameter int NOPND = 3
) (
    input  logic [NOPND-1:0][XLEN-1:0] opnd,
    input  logic [NOPND-1:0]           opnd_vld,
    input  logic [XLEN-1:0]            result,
    output logic                       carry_full,
    output logic                       carry_half
);
    logic [NOPND-1:0] gt_full;
    logic [NOPND-1:0] gt_half;

    // One unsigned comparator pair per operand slot
    for (genvar g = 0; g < NOPND; g++) begin : g_cmp
        assign gt_full[g] = opnd_vld[g] && (opnd[g] > result);
        assign gt_half[g] = opnd_vld[g] && (opnd[g][HALF-1:0] > result[HALF-1:0]);
    end

    assign carry_full = |gt_full;
    assign carry_half = |gt_half;
endmodule

// File: rtl/flagu_ovf.sv
module flagu_ovf #(
    parameter int NOPND = 3
) (
    input  logic [NOPND-1:0] sgn_full,
    input  logic [NOPND-1:0] sgn_half,
    input  logic [NOPND-1:0] opnd_vld,
    input  logic             res_sgn_full,
    input  logic             res_sgn_half,
    output logic             two_present,
    output logic             ovf_full,
    output logic             ovf_half
);
    logic [1:0] seen;
    logic       a_full, a_half, b_full, b_half;

    // Pick the sign bits of the first two present operands, in list order
    always_comb begin
        seen   = 2'd0;
        a_full = 1'b0;
        a_half = 1'b0;
        b_full = 1'b0;
        b_half = 1'b0;
        for (int i = 0; i < NOPND; i++) begin
            if (opnd_vld[i]) begin
                if (seen == 2'd0) begin
                    a_full = sgn_full[i];
                    a_half = sgn_half[i];
                end else if (seen == 2'd1) begin
                    b_full = sgn_full[i];
                    b_half = sgn_half[i];
                end
                if (seen != 2'd2) begin
                    seen = seen + 2'd1;
                end
            end
        end
    end

    assign two_present = (seen == 2'd2);
    assign ovf_full    = two_present && (a_full == b_full) && (res_sgn_full != a_full);
    assign ovf_half    = two_present && (a_half == b_half) && (res_sgn_half != a_half);
endmodule

// File: rtl/flagu_sign.sv
module flagu_sign #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] result,
    output logic            is_neg,
    output logic            is_pos,
    output logic            is_zero
);
    assign is_neg  = result[XLEN-1];
    assign is_zero = (result == '0);
    assign is_pos  = !is_neg && !is_zero;
endmodule

// File: rtl/int_flag_unit.sv
module int_flag_unit
    import flagu_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NSRC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      op_vld,
    input  logic [NSRC-1:0][XLEN-1:0] src,
    input  logic [NSRC-1:0]           src_vld,
    input  logic                      invert_src0,
    input  logic                      imm_vld,
    input  logic [XLEN-1:0]           imm_val,
    input  logic [XLEN-1:0]           result,
    input  logic                      carry_en,
    input  logic [1:0]                carry_done,
    input  logic                      ca_pre,
    input  logic                      ca32_pre,
    input  logic                      ovf_en,
    input  logic                      div_ovf,
    input  logic                      rec_en,
    output logic                      ca_q,
    output logic                      ca32_q,
    output logic                      ov_q,
    output logic                      ov32_q,
    output logic                      so_q,
    output logic [CR_FIELD_W-1:0]     cr0_q
);
    localparam int HALF  = XLEN / 2;
    localparam int NOPND = NSRC + 1;

    flag_state_t state_d, state_q;

    logic [NOPND-1:0][XLEN-1:0] opnd;
    logic [NOPND-1:0]           opnd_vld;
    logic [NOPND-1:0]           sgn_full;
    logic [NOPND-1:0]           sgn_half;
    logic carry_full, carry_half;
    logic two_present, ovf_full, ovf_half;
    logic is_neg, is_pos, is_zero;
    logic ovf_upd;

    // Operand list: register operands in order, then the immediate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        if (g == 0) begin : g_first
            assign opnd[g] = invert_src0 ? ~src[g] : src[g];
        end else begin : g_rest
            assign opnd[g] = src[g];
        end
        assign opnd_vld[g] = src_vld[g];
    end
    assign opnd[NSRC]     = imm_val;
    assign opnd_vld[NSRC] = imm_vld;

    for (genvar g = 0; g < NOPND; g++) begin : g_sgn
        assign sgn_full[g] = opnd[g][XLEN-1];
        assign sgn_half[g] = opnd[g][HALF-1];
    end

    flagu_carry #(.XLEN(XLEN), .HALF(HALF), .NOPND(NOPND)) carry_i (
        .opnd       (opnd),
        .opnd_vld   (opnd_vld),
        .result     (result),
        .carry_full (carry_full),
        .carry_half (carry_half)
    );

    flagu_ovf #(.NOPND(NOPND)) ovf_i (
        .sgn_full     (sgn_full),
        .sgn_half     (sgn_half),
        .opnd_vld     (opnd_vld),
        .res_sgn_full (result[XLEN-1]),
        .res_sgn_half (result[HALF-1]),
        .two_present  (two_present),
        .ovf_full     (ovf_full),
        .ovf_half     (ovf_half)
    );

    flagu_sign #(.XLEN(XLEN)) sign_i (
        .result  (result),
        .is_neg  (is_neg),
        .is_pos  (is_pos),
        .is_zero (is_zero)
    );

    assign ovf_upd = ovf_en && (two_present || div_ovf);

    // Next-state computation
    always_comb begin
        state_d = state_q;
        if (op_vld) begin
            if (carry_en) begin
                state_d.ca   = carry_done[0] ? ca_pre   : carry_full;
                state_d.ca32 = carry_done[1] ? ca32_pre : carry_half;
            end
            if (ovf_upd) begin
                state_d.ov   = div_ovf | ovf_full;
                state_d.ov32 = div_ovf | ovf_half;
                state_d.so   = state_q.so | state_d.ov;
            end
            if (rec_en) begin
                state_d.cr0 = {is_neg, is_pos, is_zero, state_d.so};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign ca_q   = state_q.ca;
    assign ca32_q = state_q.ca32;
    assign ov_q   = state_q.ov;
    assign ov32_q = state_q.ov32;
    assign so_q   = state_q.so;
    assign cr0_q  = state_q.cr0;

    // R10
    so_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        so_q |=> so_q);

    // R6
    carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_vld && carry_en) |=> $stable({ca_q, ca32_q}));

    // R8
    div_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && ovf_en && div_ovf) |=> (ov_q && ov32_q && so_q));

    // R9
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && !ovf_en) |=> $stable({ov_q, ov32_q, so_q}));

    // R11
    cr0_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && rec_en) |=> ($countones(cr0_q[3:1]) == 1 && cr0_q[0] == so_q));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_vld |=> $stable({ca_q, ca32_q, ov_q, ov32_q, so_q, cr0_q}));
endmodule

// File: tb/int_flag_unit_tb_top.sv
`timescale 1ns/1ps
module int_flag_unit_tb_top;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             op_vld = 1'b0;
    logic [1:0][63:0] src = '0;
    logic [1:0]       src_vld = '0;
    logic             invert_src0 = 1'b0;
    logic             imm_vld = 1'b0;
    logic [63:0]      imm_val = '0;
    logic [63:0]      result = '0;
    logic             carry_en = 1'b0;
    logic [1:0]       carry_done = '0;
    logic             ca_pre = 1'b0;
    logic             ca32_pre = 1'b0;
    logic             ovf_en = 1'b0;
    logic             div_ovf = 1'b0;
    logic             rec_en = 1'b0;
    logic             ca_q, ca32_q, ov_q, ov32_q, so_q;
    logic [3:0]       cr0_q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    int_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .src(src), .src_vld(src_vld),
        .invert_src0(invert_src0), .imm_vld(imm_vld), .imm_val(imm_val),
        .result(result), .carry_en(carry_en), .carry_done(carry_done),
        .ca_pre(ca_pre), .ca32_pre(ca32_pre), .ovf_en(ovf_en), .div_ovf(div_ovf),
        .rec_en(rec_en), .ca_q(ca_q), .ca32_q(ca32_q), .ov_q(ov_q),
        .ov32_q(ov32_q), .so_q(so_q), .cr0_q(cr0_q)
    );

    // Stimulus with expected {ca, ca32, ov, ov32, so, cr0}; all three updates enabled
    typedef struct packed {
        logic        inv;
        logic [63:0] s0;
        logic [63:0] s1;
        logic        s1v;
        logic        immv;
        logic [63:0] imm;
        logic [63:0] res;
        logic [8:0]  exp;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 64'd5, 64'd3, 1'b1, 1'b0, 64'd0, 64'd8, 9'b00000_0100},
        '{1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b1, 1'b0, 64'd0, 64'd0, 9'b11000_0010},
        '{1'b0, 64'h0000_0000_FFFF_FFFF, 64'd1, 1'b1, 1'b0, 64'd0, 64'h0000_0001_0000_0000, 9'b01000_0100},
        '{1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b1, 1'b0, 64'd0, 64'h8000_0000_0000_0000, 9'b01101_1001},
        '{1'b0, 64'd2, 64'd2, 1'b1, 1'b0, 64'd0, 64'd4, 9'b00001_0101},
        '{1'b0, 64'h0000_0000_7FFF_FFFF, 64'd1, 1'b1, 1'b0, 64'd0, 64'h0000_0000_8000_0000, 9'b00011_0101},
        '{1'b1, 64'd5, 64'd7, 1'b1, 1'b0, 64'd0, 64'd2, 9'b11001_0101},
        '{1'b0, 64'hFFFF_FFFF_FFFF_FFFB, 64'h8000_0000_0000_0000, 1'b0, 1'b1, 64'd10, 64'd5, 9'b11001_0101},
        '{1'b0, 64'd1, 64'd2, 1'b1, 1'b1, 64'd9, 64'd6, 9'b11001_0101}
    };

    function automatic logic [8:0] outs();
        return {ca_q, ca32_q, ov_q, ov32_q, so_q, cr0_q};
    endfunction

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        op_vld = 0; src = '0; src_vld = '0; invert_src0 = 0; imm_vld = 0; imm_val = '0;
        result = '0; carry_en = 0; carry_done = '0; ca_pre = 0; ca32_pre = 0;
        ovf_en = 0; div_ovf = 0; rec_en = 0;
    endtask

    // Inputs are already set after a negedge; one posedge captures, check at next negedge
    task automatic fire();
        op_vld = 1'b1;
        @(negedge clk);
        op_vld = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 reset state", outs(), 9'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        clear_inputs();
        repeat (3) @(negedge clk);
        #1;
        chk("R1 initial reset", outs(), 9'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 R4 R7 R10 R11 table walk
        for (int v = 0; v < NVEC; v++) begin
            clear_inputs();
            invert_src0 = VECS[v].inv;
            src = {VECS[v].s1, VECS[v].s0};
            src_vld = {VECS[v].s1v, 1'b1};
            imm_vld = VECS[v].immv;
            imm_val = VECS[v].imm;
            result = VECS[v].res;
            carry_en = 1; ovf_en = 1; rec_en = 1;
            fire();
            chk($sformatf("R2/R3/R4/R7/R10/R11 vector %0d", v), outs(), VECS[v].exp);
        end

        do_reset();

        // R12: a strobe-less cycle with overflowing, carrying inputs changes nothing
        clear_inputs();
        src = {64'd1, 64'h7FFF_FFFF_FFFF_FFFF}; src_vld = 2'b11;
        result = 64'h8000_0000_0000_0000; carry_en = 1; ovf_en = 1; rec_en = 1; div_ovf = 1;
        @(negedge clk);
        @(negedge clk);
        chk("R12 idle hold", outs(), 9'b0);

        // R11: negative result with summary clear, record only
        clear_inputs();
        src = {64'hFFFF_FFFF_FFFF_FFFE, 64'd0}; src_vld = 2'b11;
        result = 64'hFFFF_FFFF_FFFF_FFFE; rec_en = 1;
        fire();
        chk("R11 negative with so clear", outs(), 9'b00000_1000);

        // R5: mask bit 0 takes ca_pre, CA32 still inferred
        clear_inputs();
        src = {64'd1, 64'hFFFF_FFFF_FFFF_FFFF}; src_vld = 2'b11; result = 64'd0;
        carry_en = 1; carry_done = 2'b01; ca_pre = 0; ca32_pre = 0;
        fire();
        chk("R5 mask bit0", outs(), 9'b01000_1000);

        clear_inputs();
        src = {64'd1, 64'hFFFF_FFFF_FFFF_FFFF}; src_vld = 2'b11; result = 64'd0;
        carry_en = 1; carry_done = 2'b10; ca_pre = 0; ca32_pre = 0;
        fire();
        chk("R5 mask bit1", outs(), 9'b10000_1000);

        clear_inputs();
        src = {64'd3, 64'd5}; src_vld = 2'b11; result = 64'd8;
        carry_en = 1; carry_done = 2'b11; ca_pre = 1; ca32_pre = 1;
        fire();
        chk("R5 mask both", outs(), 9'b11000_1000);

        // R6: carry_en low holds carries
        clear_inputs();
        src = {64'd3, 64'd5}; src_vld = 2'b11; result = 64'd8;
        fire();
        chk("R6 carry hold", outs(), 9'b11000_1000);

        // R9: one operand, no divide overflow: no overflow update
        clear_inputs();
        src = {64'd1, 64'h7FFF_FFFF_FFFF_FFFF}; src_vld = 2'b01;
        result = 64'h8000_0000_8000_0000; ovf_en = 1;
        fire();
        chk("R9 single operand gating", outs(), 9'b11000_1000);

        // R8: divide overflow forces both flags with a single operand
        clear_inputs();
        src = {64'd0, 64'd7}; src_vld = 2'b01; result = 64'd0; ovf_en = 1; div_ovf = 1;
        fire();
        chk("R8 divide overflow", outs(), 9'b11111_1000);

        // R9: ovf_en low holds overflow flags
        clear_inputs();
        src = {64'd3, 64'd5}; src_vld = 2'b11; result = 64'd8;
        fire();
        chk("R9 ovf_en low hold", outs(), 9'b11111_1000);

        // R10 R7: clean update clears OV flags, summary stays
        clear_inputs();
        src = {64'd3, 64'd5}; src_vld = 2'b11; result = 64'd8; ovf_en = 1;
        fire();
        chk("R10 sticky so after clean update", outs(), 9'b11001_1000);

        // R11: record with fresh summary
        clear_inputs();
        src = {64'd3, 64'd5}; src_vld = 2'b11; result = 64'd8; rec_en = 1;
        fire();
        chk("R11 positive with so set", outs(), 9'b11001_0101);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule